// File: doc/BRIEF.md
# Guarded SPI Packet Master

This block is an SPI bus master, running in mode 0, that moves packets of variable length to and from a slave that has no ready wire. The slave shows whether it is ready only through the bytes it returns on MISO. A ready slave returns 0x00. Any other value means the slave was not listening. On such a value the master raises chip select, waits a backoff interval and runs the same transaction again from its first byte.

To send a packet, the host pulses a start input together with a 16-bit length. The engine then sends a two-byte length transaction, followed by payload transactions of at most MTU bytes each. It fetches each payload byte from the host through an index/data pair. A read begins when the slave pulls its active-low request line. The engine sends a header of two zero bytes, then reads a three-byte transaction made of a guard byte and the 16-bit length. After that it reads frames, and each frame starts with a guard byte. Received payload bytes come out as single-cycle beats tagged with their offset in the packet. A retry budget is kept for each transaction. When it runs out, the engine reports an error and goes back to idle.

Top module: `gpk_spi_master`

## Requirements
- R1: After reset, cs_n is high, sclk is low, busy is low and no done, err, rd_valid or rd_len_valid pulse appears. Whenever busy is low, cs_n is high.
- R2: The bus runs in SPI mode 0. sclk is low whenever cs_n is high. MOSI changes only while sclk is low. Bits go MSB first, and each sclk level lasts DIV clock cycles.
- R3: A write of L bytes first sends a 2-byte header transaction that carries L least significant byte first. It then sends payload transactions of MTU bytes in packet order, and the last one carries the remainder. When L is 0, only the header transaction is sent.
- R4: In every transaction the engine drives (the write header, the write payload and the zero header of a read), each MISO byte must be 0x00. A nonzero byte ends the transaction: cs_n rises after that byte and no further byte is clocked.
- R5: After an abort, cs_n stays high for at least BACKOFF clock cycles. The same transaction is then repeated from its first byte, with the same MOSI content.
- R6: When idle with req_n low, the engine starts a read by sending a zero header of two 0x00 bytes. If wr_start and req_n are both active in the same cycle, the write goes first.
- R7: After the zero header, the engine reads a 3-byte transaction with MOSI at 0x00. Byte 0 is the guard byte. Bytes 1 and 2 are the packet length, least significant byte first. That length appears on rd_len with a one-cycle rd_len_valid pulse.
- R8: Each read frame is one guard byte followed by up to MTU-1 payload bytes. Every payload byte appears on rd_data with a one-cycle rd_valid pulse and its packet offset on rd_idx. MISO bytes after the guard byte are taken without any check.
- R9: In a read transaction, only byte 0 is checked. If it is nonzero, cs_n rises after that single byte, the frame is retried (R5), and the aborted attempt produces no rd_valid pulse.
- R10: Each transaction may be retried at most MAX_RETRY times in a row. The next failure after that produces an err pulse with no done pulse, and busy then falls.
- R11: When a packet completes, exactly one done pulse appears, and busy falls afterwards. done and err never pulse in the same cycle.
- R12: The retry budget starts afresh at each transaction. Failures spread over several transactions of one packet, each within its own budget, still end in done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Pulse that starts a packet write |
| wr_len | input | LEN_W | Byte count of the packet to write, sampled with wr_start |
| wr_idx | output | LEN_W | Packet offset of the payload byte needed now |
| wr_data | input | 8 | Payload byte at wr_idx, supplied combinationally |
| req_n | input | 1 | Active-low read request from the slave |
| rd_len | output | LEN_W | Length of the packet being read |
| rd_len_valid | output | 1 | One-cycle pulse when rd_len is updated |
| rd_data | output | 8 | Received payload byte |
| rd_idx | output | LEN_W | Packet offset of rd_data |
| rd_valid | output | 1 | One-cycle pulse for each received payload byte |
| busy | output | 1 | Packet operation in progress |
| done | output | 1 | One-cycle pulse at packet completion |
| err | output | 1 | One-cycle pulse when the retry budget is exhausted |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | Master-out serial data |
| miso | input | 1 | Master-in serial data |
| cs_n | output | 1 | Active-low chip select |

## Verification
A wrong frame offset or byte counter shows up at the ports within one transaction. Transactions come out too long or too short, MOSI carries the wrong payload bytes, or rd_idx values are off by a frame. A retry or transaction-kind register that does not restart correctly shows up on the next abort. The repeated transaction either carries different MOSI bytes, or starts before the backoff has elapsed. A stale retry counter shows up as a spurious err pulse in a packet whose failures are spread across several transactions. A guard check applied to the wrong byte is caught in two ways: by payload bytes that go missing, or by rd_valid beats that appear during an aborted frame.

// File: rtl/gpk_pkg.sv
package gpk_pkg;

    // Transaction kinds, in the order a packet walks through them
    typedef enum logic [2:0] {
        K_WHDR,
        K_WFRM,
        K_RZERO,
        K_RHDR,
        K_RFRM
    } txn_kind_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEL,
        S_LAUNCH,
        S_SHIFT,
        S_WAIT
    } seq_state_t;

    // Result of one byte exchange on the bus
    typedef struct packed {
        logic       fin;
        logic [7:0] rx;
    } byte_res_t;

    // Transactions the master drives: every returned byte must be zero
    function automatic logic all_bytes_checked(txn_kind_t k);
        return (k == K_WHDR) || (k == K_WFRM) || (k == K_RZERO);
    endfunction

    // Readiness verdict for one received byte
    function automatic logic byte_ready(txn_kind_t k, logic first, logic [7:0] rx);
        if (all_bytes_checked(k) || first)
            return (rx == 8'h00);
        return 1'b1;
    endfunction

endpackage

// File: rtl/gpk_byte_shift.sv
module gpk_byte_shift
    import gpk_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output byte_res_t  res
);
    localparam int DW = $clog2(DIV + 1);

    logic          active_q;
    logic          sclk_q;
    logic [DW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    tx_q;
    logic [7:0]    rx_q;
    logic          fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            div_q    <= '0;
            bit_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                active_q <= 1'b1;
                sclk_q   <= 1'b0;
                div_q    <= '0;
                bit_q    <= '0;
                tx_q     <= tx_byte;
            end else if (active_q) begin
                if (div_q == DW'(DIV - 1)) begin
                    div_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_q   <= {rx_q[6:0], miso};
                    end else begin
                        sclk_q <= 1'b0;
                        if (bit_q == 3'd7) begin
                            active_q <= 1'b0;
                            fin_q    <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            tx_q  <= {tx_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_q <= div_q + DW'(1);
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = tx_q[7];
    assign res.fin = fin_q;
    assign res.rx  = rx_q;

endmodule

// File: rtl/gpk_wait_timer.sv
module gpk_wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= value;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/gpk_sequencer.sv
module gpk_sequencer
    import gpk_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MTU       = 4,
    parameter int BACKOFF   = 6,
    parameter int GAP       = 2,
    parameter int MAX_RETRY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_start,
    input  logic [LEN_W-1:0] wr_len,
    output logic [LEN_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             req_n,
    output logic [LEN_W-1:0] rd_len,
    output logic             rd_len_valid,
    output logic [7:0]       rd_data,
    output logic [LEN_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             cs_n,
    output logic             go,
    output logic [7:0]       tx_byte,
    input  byte_res_t        res,
    output logic             tmr_load,
    output logic [$clog2(((BACKOFF > GAP) ? BACKOFF : GAP) + 1)-1:0] tmr_value,
    input  logic             tmr_expired
);
    localparam int GAP_EFF = (GAP < 1) ? 1 : GAP;
    localparam int BO_EFF  = (BACKOFF < 1) ? 1 : BACKOFF;
    localparam int TMR_W   = $clog2(((BACKOFF > GAP) ? BACKOFF : GAP) + 1);
    localparam int RTY_W   = $clog2(MAX_RETRY + 2);

    seq_state_t       state_q;
    txn_kind_t        kind_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] pos_q;
    logic [LEN_W-1:0] bcnt_q;
    logic [RTY_W-1:0] retry_q;
    logic [7:0]       hdr_lo_q;
    logic             fin_q;
    logic             cs_n_q;
    logic             done_q;
    logic             err_q;
    logic             rdv_q;
    logic             rlv_q;
    logic [7:0]       rdd_q;
    logic [LEN_W-1:0] rdi_q;

    logic [LEN_W-1:0] rem;
    logic [LEN_W-1:0] tlen;
    logic             last_byte;
    logic             ok_byte;
    logic [LEN_W-1:0] new_len;
    logic             tmr_load_c;
    logic [TMR_W-1:0] tmr_value_c;

    // Bytes in the current transaction
    always_comb begin
        rem = len_q - pos_q;
        unique case (kind_q)
            K_WHDR, K_RZERO: tlen = LEN_W'(2);
            K_RHDR:          tlen = LEN_W'(3);
            K_WFRM:          tlen = (rem > LEN_W'(MTU)) ? LEN_W'(MTU) : rem;
            default:         tlen = LEN_W'(1) +
                                    ((rem > LEN_W'(MTU - 1)) ? LEN_W'(MTU - 1) : rem);
        endcase
    end

    // Outgoing byte
    always_comb begin
        unique case (kind_q)
            K_WHDR:  tx_byte = (bcnt_q == '0) ? len_q[7:0] : len_q[15:8];
            K_WFRM:  tx_byte = wr_data;
            default: tx_byte = 8'h00;
        endcase
    end

    assign wr_idx    = pos_q + bcnt_q;
    assign go        = (state_q == S_LAUNCH);
    assign last_byte = (bcnt_q == tlen - LEN_W'(1));
    assign ok_byte   = byte_ready(kind_q, bcnt_q == '0, res.rx);
    assign new_len   = {res.rx, hdr_lo_q};

    // Timer control
    always_comb begin
        tmr_load_c  = 1'b0;
        tmr_value_c = TMR_W'(GAP_EFF);
        if (state_q == S_SHIFT && res.fin) begin
            tmr_load_c = 1'b1;
            if (!ok_byte && retry_q != RTY_W'(MAX_RETRY))
                tmr_value_c = TMR_W'(BO_EFF);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            kind_q   <= K_WHDR;
            len_q    <= '0;
            pos_q    <= '0;
            bcnt_q   <= '0;
            retry_q  <= '0;
            hdr_lo_q <= '0;
            fin_q    <= 1'b0;
            cs_n_q   <= 1'b1;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            rdv_q    <= 1'b0;
            rlv_q    <= 1'b0;
            rdd_q    <= '0;
            rdi_q    <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            rdv_q  <= 1'b0;
            rlv_q  <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    retry_q <= '0;
                    pos_q   <= '0;
                    fin_q   <= 1'b0;
                    if (wr_start) begin
                        len_q   <= wr_len;
                        kind_q  <= K_WHDR;
                        state_q <= S_SEL;
                    end else if (!req_n) begin
                        len_q   <= '0;
                        kind_q  <= K_RZERO;
                        state_q <= S_SEL;
                    end
                end
                S_SEL: begin
                    cs_n_q  <= 1'b0;
                    bcnt_q  <= '0;
                    state_q <= S_LAUNCH;
                end
                S_LAUNCH: state_q <= S_SHIFT;
                S_SHIFT: begin
                    if (res.fin) begin
                        if (!ok_byte) begin
                            cs_n_q  <= 1'b1;
                            state_q <= S_WAIT;
                            if (retry_q == RTY_W'(MAX_RETRY)) begin
                                err_q <= 1'b1;
                                fin_q <= 1'b1;
                            end else begin
                                retry_q <= retry_q + RTY_W'(1);
                            end
                        end else begin
                            if (kind_q == K_RFRM && bcnt_q != '0) begin
                                rdv_q <= 1'b1;
                                rdd_q <= res.rx;
                                rdi_q <= pos_q + bcnt_q - LEN_W'(1);
                            end
                            if (kind_q == K_RHDR && bcnt_q == LEN_W'(1))
                                hdr_lo_q <= res.rx;
                            if (last_byte) begin
                                cs_n_q  <= 1'b1;
                                retry_q <= '0;
                                state_q <= S_WAIT;
                                unique case (kind_q)
                                    K_WHDR: begin
                                        if (len_q == '0) begin
                                            fin_q  <= 1'b1;
                                            done_q <= 1'b1;
                                        end else begin
                                            kind_q <= K_WFRM;
                                        end
                                    end
                                    K_WFRM: begin
                                        if (pos_q + tlen >= len_q) begin
                                            fin_q  <= 1'b1;
                                            done_q <= 1'b1;
                                        end else begin
                                            pos_q <= pos_q + tlen;
                                        end
                                    end
                                    K_RZERO: kind_q <= K_RHDR;
                                    K_RHDR: begin
                                        len_q <= new_len;
                                        rlv_q <= 1'b1;
                                        if (new_len == '0) begin
                                            fin_q  <= 1'b1;
                                            done_q <= 1'b1;
                                        end else begin
                                            kind_q <= K_RFRM;
                                        end
                                    end
                                    default: begin
                                        if (pos_q + tlen - LEN_W'(1) >= len_q) begin
                                            fin_q  <= 1'b1;
                                            done_q <= 1'b1;
                                        end else begin
                                            pos_q <= pos_q + tlen - LEN_W'(1);
                                        end
                                    end
                                endcase
                            end else begin
                                bcnt_q  <= bcnt_q + LEN_W'(1);
                                state_q <= S_LAUNCH;
                            end
                        end
                    end
                end
                default: begin
                    if (tmr_expired)
                        state_q <= fin_q ? S_IDLE : S_SEL;
                end
            endcase
        end
    end

    assign tmr_load     = tmr_load_c;
    assign tmr_value    = tmr_value_c;
    assign cs_n         = cs_n_q;
    assign busy         = (state_q != S_IDLE);
    assign done         = done_q;
    assign err          = err_q;
    assign rd_valid     = rdv_q;
    assign rd_len_valid = rlv_q;
    assign rd_data      = rdd_q;
    assign rd_idx       = rdi_q;
    assign rd_len       = len_q;

endmodule

// File: rtl/gpk_spi_master.sv
module gpk_spi_master
    import gpk_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MTU       = 4,
    parameter int DIV       = 2,
    parameter int BACKOFF   = 6,
    parameter int GAP       = 2,
    parameter int MAX_RETRY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_start,
    input  logic [LEN_W-1:0] wr_len,
    output logic [LEN_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             req_n,
    output logic [LEN_W-1:0] rd_len,
    output logic             rd_len_valid,
    output logic [7:0]       rd_data,
    output logic [LEN_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    localparam int TMR_W = $clog2(((BACKOFF > GAP) ? BACKOFF : GAP) + 1);

    logic             go;
    logic [7:0]       tx_byte;
    byte_res_t        res;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_value;
    logic             tmr_expired;

    gpk_sequencer #(
        .LEN_W(LEN_W), .MTU(MTU), .BACKOFF(BACKOFF), .GAP(GAP), .MAX_RETRY(MAX_RETRY)
    ) seq_i (
        .clk(clk), .rst(rst),
        .wr_start(wr_start), .wr_len(wr_len), .wr_idx(wr_idx), .wr_data(wr_data),
        .req_n(req_n),
        .rd_len(rd_len), .rd_len_valid(rd_len_valid), .rd_data(rd_data),
        .rd_idx(rd_idx), .rd_valid(rd_valid),
        .busy(busy), .done(done), .err(err), .cs_n(cs_n),
        .go(go), .tx_byte(tx_byte), .res(res),
        .tmr_load(tmr_load), .tmr_value(tmr_value), .tmr_expired(tmr_expired)
    );

    gpk_byte_shift #(.DIV(DIV)) shift_i (
        .clk(clk), .rst(rst), .go(go), .tx_byte(tx_byte), .miso(miso),
        .sclk(sclk), .mosi(mosi), .res(res)
    );

    gpk_wait_timer #(.W(TMR_W)) tmr_i (
        .clk(clk), .rst(rst), .load(tmr_load), .value(tmr_value), .expired(tmr_expired)
    );

endmodule

// File: rtl/gpk_checker.sv
module gpk_checker (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic busy,
    input logic done,
    input logic err,
    input logic rd_valid
);
    // R1
    idle_cs_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> cs_n);

    // R2
    sclk_park_chk: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk);

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R11
    done_err_excl_chk: assert property (@(posedge clk) disable iff (rst) !(done && err));

    // R8
    rd_beat_busy_chk: assert property (@(posedge clk) disable iff (rst) rd_valid |-> busy);

    // R10
    err_released_chk: assert property (@(posedge clk) disable iff (rst) err |-> cs_n);
endmodule

bind gpk_spi_master gpk_checker chk_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .busy(busy), .done(done), .err(err), .rd_valid(rd_valid)
);

// File: tb/gpk_spi_master_tb.sv
module gpk_spi_master_tb_top;
    localparam int LEN_W = 16;
    localparam int MTU = 4;
    localparam int BACKOFF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_start = 1'b0;
    logic [LEN_W-1:0] wr_len = '0;
    logic [LEN_W-1:0] wr_idx;
    logic [7:0] wr_data;
    logic req_n = 1'b1;
    logic [LEN_W-1:0] rd_len, rd_idx;
    logic rd_len_valid, rd_valid, busy, done, err, sclk, mosi, miso, cs_n;
    logic [7:0] rd_data;

    logic [7:0] wbuf [0:31];
    assign wr_data = wbuf[wr_idx[4:0]];

    gpk_spi_master #(.LEN_W(LEN_W), .MTU(MTU), .DIV(2), .BACKOFF(BACKOFF),
                     .GAP(2), .MAX_RETRY(2)) dut_i (
        .clk(clk), .rst(rst), .wr_start(wr_start), .wr_len(wr_len), .wr_idx(wr_idx),
        .wr_data(wr_data), .req_n(req_n), .rd_len(rd_len), .rd_len_valid(rd_len_valid),
        .rd_data(rd_data), .rd_idx(rd_idx), .rd_valid(rd_valid), .busy(busy),
        .done(done), .err(err), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    int last_len = -1;

    // Slave model state
    logic [7:0] sbytes [0:63][0:7];
    logic [7:0] mbytes [0:63][0:7];
    int tcnt [0:63];
    longint tstart [0:63];
    longint tend [0:63];
    int tidx = 0;
    int bidx = 0;
    int bitc = 0;
    logic [7:0] sh = 8'hFF;
    logic [7:0] rxsh = 8'h00;
    logic pcs = 1'b1;
    logic psclk = 1'b0;

    assign miso = sh[7];

    // Scoreboard of expected read beats: {idx, data}
    logic [23:0] exp_q [$];

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(cs_n or sclk) begin
        if (cs_n !== pcs) begin
            if (cs_n === 1'b0) begin
                tstart[tidx] = cyc;
                bidx = 0;
                bitc = 0;
                sh = sbytes[tidx][0];
            end else if (pcs === 1'b0) begin
                tcnt[tidx] = bidx;
                tend[tidx] = cyc;
                tidx++;
            end
        end else if (cs_n === 1'b0 && sclk !== psclk) begin
            if (sclk === 1'b1) begin
                rxsh = {rxsh[6:0], mosi};
            end else begin
                bitc++;
                if (bitc == 8) begin
                    mbytes[tidx][bidx] = rxsh;
                    bidx++;
                    bitc = 0;
                    sh = (bidx < 8) ? sbytes[tidx][bidx] : 8'hFF;
                end else begin
                    sh = {sh[6:0], 1'b0};
                end
            end
        end
        pcs = cs_n;
        psclk = sclk;
    end

    // Monitor: pops expected read beats
    always @(negedge clk) begin
        if (done) done_cnt++;
        if (err) err_cnt++;
        if (rd_len_valid) last_len = int'(rd_len);
        if (rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8/R9 unexpected beat: actual %0h@%0d expected none", rd_data, rd_idx);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                if ({rd_idx, rd_data} != e) begin
                    errors++;
                    $display("FAIL R8 beat: actual %0h expected %0h", {rd_idx, rd_data}, e);
                end
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic start_write(input int len);
        @(negedge clk);
        wr_len = LEN_W'(len);
        wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    initial begin
        int b, d0, e0;
        for (int t = 0; t < 64; t++)
            for (int k = 0; k < 8; k++) begin
                sbytes[t][k] = 8'h00;
                mbytes[t][k] = 8'h00;
            end
        for (int k = 0; k < 32; k++) wbuf[k] = 8'hA0 + 8'(k);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cs_n", cs_n, 1);
        chk("R1", "sclk", sclk, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);

        // Write 6 bytes, slave always ready (R3, R2, R11)
        b = tidx; d0 = done_cnt;
        start_write(6);
        wait_idle();
        chk("R3", "txn count", tidx - b, 3);
        chk("R3", "hdr lo", mbytes[b][0], 6);
        chk("R3", "hdr hi", mbytes[b][1], 0);
        chk("R3", "frame1 len", tcnt[b+1], 4);
        chk("R2", "frame1 byte0", mbytes[b+1][0], 8'hA0);
        chk("R3", "frame1 byte3", mbytes[b+1][3], 8'hA3);
        chk("R3", "frame2 len", tcnt[b+2], 2);
        chk("R3", "frame2 byte1", mbytes[b+2][1], 8'hA5);
        chk("R11", "done count", done_cnt - d0, 1);

        // Write with spread failures (R4, R5, R12)
        b = tidx; d0 = done_cnt; e0 = err_cnt;
        sbytes[b][0] = 8'hFF;
        sbytes[b+1][1] = 8'h80;
        sbytes[b+3][3] = 8'h01;
        sbytes[b+4][0] = 8'h40;
        start_write(6);
        wait_idle();
        chk("R12", "txn count", tidx - b, 7);
        chk("R4", "abort after byte0", tcnt[b], 1);
        chk("R4", "abort after byte1", tcnt[b+1], 2);
        chk("R5", "backoff gap ok", (tstart[b+1] - tend[b]) >= BACKOFF, 1);
        chk("R5", "retry hdr lo", mbytes[b+2][0], 6);
        chk("R5", "retry frame byte2", mbytes[b+3][2], 8'hA2);
        chk("R5", "completed frame byte0", mbytes[b+5][0], 8'hA0);
        chk("R5", "completed frame byte3", mbytes[b+5][3], 8'hA3);
        chk("R12", "done", done_cnt - d0, 1);
        chk("R12", "no err", err_cnt - e0, 0);

        // Read 5 bytes (R6, R7, R8)
        b = tidx; d0 = done_cnt;
        sbytes[b+1][0] = 8'h00; sbytes[b+1][1] = 8'h05; sbytes[b+1][2] = 8'h00;
        sbytes[b+2][1] = 8'h11; sbytes[b+2][2] = 8'h22; sbytes[b+2][3] = 8'h33;
        sbytes[b+3][1] = 8'h44; sbytes[b+3][2] = 8'h55;
        exp_q.push_back({16'd0, 8'h11}); exp_q.push_back({16'd1, 8'h22});
        exp_q.push_back({16'd2, 8'h33}); exp_q.push_back({16'd3, 8'h44});
        exp_q.push_back({16'd4, 8'h55});
        @(negedge clk) req_n = 1'b0;
        wait (tidx > b);
        @(negedge clk) req_n = 1'b1;
        wait_idle();
        chk("R6", "zero hdr len", tcnt[b], 2);
        chk("R6", "zero hdr byte1", mbytes[b][1], 0);
        chk("R7", "rx hdr len", tcnt[b+1], 3);
        chk("R7", "rd_len", last_len, 5);
        chk("R8", "frame1 len", tcnt[b+2], 4);
        chk("R8", "frame2 len", tcnt[b+3], 3);
        chk("R8", "beats left", exp_q.size(), 0);
        chk("R11", "done", done_cnt - d0, 1);

        // Read with bad guard (R9)
        b = tidx;
        sbytes[b+1][1] = 8'h03;
        sbytes[b+2][0] = 8'h5A; sbytes[b+2][1] = 8'h99; sbytes[b+2][2] = 8'h99; sbytes[b+2][3] = 8'h99;
        sbytes[b+3][1] = 8'hA1; sbytes[b+3][2] = 8'hA2; sbytes[b+3][3] = 8'hA3;
        exp_q.push_back({16'd0, 8'hA1}); exp_q.push_back({16'd1, 8'hA2});
        exp_q.push_back({16'd2, 8'hA3});
        @(negedge clk) req_n = 1'b0;
        wait (tidx > b);
        @(negedge clk) req_n = 1'b1;
        wait_idle();
        chk("R9", "aborted frame len", tcnt[b+2], 1);
        chk("R9", "retried frame len", tcnt[b+3], 4);
        chk("R9", "beats left", exp_q.size(), 0);

        // Retry exhaustion (R10)
        b = tidx; d0 = done_cnt; e0 = err_cnt;
        sbytes[b][0] = 8'hFF; sbytes[b+1][0] = 8'hFF; sbytes[b+2][0] = 8'hFF;
        start_write(2);
        wait_idle();
        chk("R10", "attempts", tidx - b, 3);
        chk("R10", "err", err_cnt - e0, 1);
        chk("R10", "no done", done_cnt - d0, 0);
        chk("R10", "busy low", busy, 0);

        // Zero-length write (R3)
        b = tidx; d0 = done_cnt;
        start_write(0);
        wait_idle();
        chk("R3", "zero len txns", tidx - b, 1);
        chk("R3", "zero len done", done_cnt - d0, 1);

        // Priority: write and read request together (R6)
        b = tidx;
        wbuf[0] = 8'h5E;
        sbytes[b+3][1] = 8'h01;
        sbytes[b+4][1] = 8'h3C;
        exp_q.push_back({16'd0, 8'h3C});
        @(negedge clk);
        wr_len = 16'd1; wr_start = 1'b1; req_n = 1'b0;
        @(negedge clk);
        wr_start = 1'b0;
        wait (tidx > b + 2);
        @(negedge clk) req_n = 1'b1;
        wait (tidx >= b + 5);
        wait_idle();
        chk("R6", "write first hdr", mbytes[b][0], 1);
        chk("R6", "write payload", mbytes[b+1][0], 8'h5E);
        chk("R6", "then zero hdr", tcnt[b+2], 2);
        chk("R8", "short frame len", tcnt[b+4], 2);
        chk("R8", "beats left", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule